// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block sends one 8-bit companded voice sample per frame on a serial line. A frame sync input marks the start of each frame, and a bit clock paces the bits. Both inputs come from outside the system clock domain. The block brings them into the system clock domain and detects their rising and falling edges there. The sample word arrives in parallel and is already companded. A law select picks between A-law and μ-law line coding. The line is driven only during the block's own 8-bit slot and is released at all other times, so several ports can share one wire-ORed bus.

On a sync rising edge the block captures the sample word and the law select into a holding register. The most significant bit goes onto the line at once. The next seven bit-clock rising edges each launch one more bit, and the eighth bit-clock rising edge releases the line. A free-running counter watches the sync input. If the sync shows no edge for more than two nominal frame periods, in either state, the section enters power-down. The next sync edge clears power-down.

Top module: `pcm_tx_port`

## Requirements
- R1: While reset is asserted and right after it, `sdata_oe_o` is 0, `sdata_o` is 0 and `pdn_o` is 0.
- R2: A rising edge on `fsync_i` (with `en_i` = 1) starts a slot. Bit 7 of the captured word is driven at once, and bits 6 down to 0 follow in that order, one on each of the next seven rising edges of `bclk_i`.
- R3: The eighth rising edge of `bclk_i` after the slot start releases the line. Whenever the line is released, `sdata_oe_o` is 0 and `sdata_o` is 0. Further bit-clock pulses before the next sync rising edge do not drive the line.
- R4: With `alaw_i` = 1, the word sent is the sample XOR 8'h55: bits 6, 4, 2 and 0 are inverted, which are the even-numbered bits when the MSB is counted as bit 1. With `alaw_i` = 0, the sample is sent unchanged.
- R5: The sample and the law select are captured at the slot start. Changes to `sample_i` or `alaw_i` during the slot do not change the bits sent.
- R6: If `fsync_i` shows no edge for more than 2*FRAME_CYCLES system clocks, `pdn_o` becomes 1. This holds whether the sync is stuck low or stuck high. The next sync edge clears `pdn_o`.
- R7: While `pdn_o` = 1 the line is released, including a slot already in progress, and bit-clock pulses have no effect. A sync rising edge starts a new slot at once.
- R8: With `en_i` = 0 no slot starts. Dropping `en_i` during a slot releases the line on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Transmit enable |
| alaw_i | input | 1 | 1 = A-law line coding, 0 = μ-law |
| sample_i | input | 8 | Companded sample word |
| fsync_i | input | 1 | Frame sync (asynchronous) |
| bclk_i | input | 1 | Bit clock (asynchronous) |
| sdata_o | output | 1 | Serial data, forced to 0 when released |
| sdata_oe_o | output | 1 | Line drive enable |
| pdn_o | output | 1 | Transmit power-down flag |

## Verification
A wrong bit index or a wrong shift state shows up as a wrong bit during the slot. A release that comes one edge early or one edge late shows up as a wrong drive-enable value at the mid-point of the bit cell that follows. The scoreboard checks every bit cell, so such an error is reported within one bit period. A holding register that keeps tracking the sample input shows up as corrupted bits after a mid-slot change to the word. A wrong threshold in the stall counter shows up as `pdn_o` changing on the wrong side of the two-frame limit. The bench samples `pdn_o` shortly before and shortly after that limit.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  parameter int WORD_BITS = 8;
  typedef logic [WORD_BITS-1:0] pcm_word_t;

  // invert code bits 2,4,6,.. counted from the MSB as bit 1
  function automatic pcm_word_t alaw_line_code(pcm_word_t w);
    pcm_word_t r;
    for (int i = 0; i < WORD_BITS; i++)
      r[i] = (((WORD_BITS - i) % 2) == 0) ? ~w[i] : w[i];
    return r;
  endfunction
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], a_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/pcm_tx_stall.sv
module pcm_tx_stall #(
  parameter int LIMIT = 31250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic pdn_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pdn_o <= 1'b0;
    end else if (activity_i) begin
      cnt_q <= '0;
      pdn_o <= 1'b0;
    end else if (cnt_q == CW'(LIMIT)) begin
      pdn_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      step_i,
  input  logic      abort_i,
  input  pcm_word_t word_i,
  output logic      sd_o,
  output logic      oe_o
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  pcm_word_t      sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic           active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sreg_q   <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sreg_q   <= word_i;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (step_i && active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        sreg_q <= {sreg_q[WORD_BITS-2:0], 1'b0};
      end
    end
  end

  assign sd_o = active_q & sreg_q[WORD_BITS-1];
  assign oe_o = active_q;
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int FRAME_CYCLES = 15625,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 alaw_i,
  input  logic [WORD_BITS-1:0] sample_i,
  input  logic                 fsync_i,
  input  logic                 bclk_i,
  output logic                 sdata_o,
  output logic                 sdata_oe_o,
  output logic                 pdn_o
);
  localparam int STALL_LIMIT = 2 * FRAME_CYCLES;
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in, rise_v, fall_v;
  logic sync_rise, sync_edge, bclk_rise, start;
  pcm_word_t line_word;

  assign raw_in = {bclk_i, fsync_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_edge
    pcm_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (raw_in[g]),
      .rise_o(rise_v[g]),
      .fall_o(fall_v[g])
    );
  end

  assign sync_rise = rise_v[0];
  assign sync_edge = rise_v[0] | fall_v[0];
  assign bclk_rise = rise_v[1];

  pcm_tx_stall #(.LIMIT(STALL_LIMIT)) u_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .activity_i(sync_edge),
    .pdn_o     (pdn_o)
  );

  assign line_word = alaw_i ? alaw_line_code(sample_i) : sample_i;
  assign start     = sync_rise & en_i;

  pcm_tx_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .step_i (bclk_rise),
    .abort_i(pdn_o | ~en_i),
    .word_i (line_word),
    .sd_o   (sdata_o),
    .oe_o   (sdata_oe_o)
  );
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sync_rise,
  input logic sync_edge,
  input logic bclk_rise,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic pdn_o
);
  // R3
  released_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);

  // R2
  slot_from_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(sync_rise));

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && $past(sdata_oe_o) && !$past(sync_rise) && !$past(bclk_rise))
      |-> $stable(sdata_o));

  // R7
  pdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_o && !sync_edge) |=> !sdata_oe_o);

  // R8
  disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sdata_oe_o);

  // R6
  pdn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdn_o) |-> !$past(sync_edge));
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .sync_rise (sync_rise),
  .sync_edge (sync_edge),
  .bclk_rise (bclk_rise),
  .sdata_o   (sdata_o),
  .sdata_oe_o(sdata_oe_o),
  .pdn_o     (pdn_o)
);

// File: tb/pcm_tx_port_test.sv
`timescale 1ns/1ps
module pcm_tx_port_test;
  localparam int FRAME = 200;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b1, alaw_i = 1'b0, fsync_i = 1'b0, bclk_i = 1'b0;
  logic [7:0] sample_i = 8'h00;
  logic sdata_o, sdata_oe_o, pdn_o;

  int checks = 0, errors = 0;
  logic strobe = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  pcm_tx_port #(.FRAME_CYCLES(FRAME)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .alaw_i(alaw_i),
    .sample_i(sample_i), .fsync_i(fsync_i), .bclk_i(bclk_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .pdn_o(pdn_o)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver side: queue the expectation, then raise the monitor strobe
  task automatic probe(input logic oe, input logic d, input string tag);
    exp_t e;
    e.oe = oe; e.d = oe ? d : 1'b0; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (strobe && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (sdata_oe_o !== e.oe || sdata_o !== e.d) begin
          errors++;
          $display("FAIL %s actual oe=%b d=%b expected oe=%b d=%b",
                   e.tag, sdata_oe_o, sdata_o, e.oe, e.d);
        end
      end
    end
  end

  task automatic bit_pulse(input string tag);
    bclk_i = 1'b1; idle(6);
    probe(1'b0, 1'b0, tag);
    idle(2); bclk_i = 1'b0; idle(8);
  endtask

  task automatic run_frame(input logic [7:0] w, input logic law,
                           input logic chg, input string tag);
    logic [7:0] e;
    e = law ? (w ^ 8'h55) : w;
    sample_i = w; alaw_i = law;
    @(negedge clk); fsync_i = 1'b1;
    idle(6);
    probe(en_i, e[7], tag);
    for (int i = 1; i <= 8; i++) begin
      bclk_i = 1'b1; idle(6);
      if (i < 8) probe(en_i, e[7-i], tag);
      else       probe(1'b0, 1'b0, "R3");
      if (i == 1) fsync_i = 1'b0;
      idle(2); bclk_i = 1'b0; idle(8);
      if (chg && i == 3) begin
        sample_i = ~w; alaw_i = ~law;
      end
    end
    bit_pulse("R3");
    bit_pulse("R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check_eq(sdata_oe_o, 1'b0, "R1 oe in reset");
    check_eq(sdata_o, 1'b0, "R1 data in reset");
    check_eq(pdn_o, 1'b0, "R1 pdn in reset");
    rst_ni = 1'b1;
    idle(4);
    check_eq(sdata_oe_o, 1'b0, "R1 oe after reset");

    // R2 mu-law patterns
    run_frame(8'hA5, 1'b0, 1'b0, "R2");
    run_frame(8'h81, 1'b0, 1'b0, "R2");
    // R4 A-law inversion
    run_frame(8'h00, 1'b1, 1'b0, "R4");
    run_frame(8'hF3, 1'b1, 1'b0, "R4");
    // R5 mid-slot word and law change
    run_frame(8'h3C, 1'b0, 1'b1, "R5");
    run_frame(8'hC6, 1'b1, 1'b1, "R5");

    // R6 stuck low: last sync edge was about 175 cycles ago
    idle(180);
    check_eq(pdn_o, 1'b0, "R6 before limit");
    idle(120);
    check_eq(pdn_o, 1'b1, "R6 stuck low");
    // R7 bit clocks ignored in power-down
    bit_pulse("R7");
    bit_pulse("R7");
    run_frame(8'h5A, 1'b0, 1'b0, "R7");
    check_eq(pdn_o, 1'b0, "R7 cleared by sync");

    // R6 stuck high, aborts the slot it started
    sample_i = 8'h80; alaw_i = 1'b0;
    @(negedge clk); fsync_i = 1'b1;
    idle(6);
    probe(1'b1, 1'b1, "R7 slot start");
    idle(450);
    check_eq(pdn_o, 1'b1, "R6 stuck high");
    probe(1'b0, 1'b0, "R7 slot aborted");
    fsync_i = 1'b0; idle(6);
    check_eq(pdn_o, 1'b0, "R6 cleared by fall");

    // R8 disabled: nothing driven
    en_i = 1'b0;
    run_frame(8'hFF, 1'b0, 1'b0, "R8");
    en_i = 1'b1;
    // R8 drop mid-slot
    sample_i = 8'hFF;
    @(negedge clk); fsync_i = 1'b1;
    idle(6);
    probe(1'b1, 1'b1, "R8 slot start");
    en_i = 1'b0; idle(3);
    probe(1'b0, 1'b0, "R8 dropped");
    en_i = 1'b1; fsync_i = 1'b0;
    bit_pulse("R8");
    run_frame(8'h69, 1'b1, 1'b0, "R2");

    idle(10);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule